// File: doc/BRIEF.md
# UART Baud Divisor Search Engine

This block picks the oversampling ratio and the bit-period divisor for a UART receiver/transmitter. It takes an input clock frequency and a requested baud rate in hertz and finds the pair whose actual rate is closest to the request. The search is sequential. One shared restoring divider produces the three quotients needed per ratio. Each ratio from 4 to 32 compares a floor divisor with the next divisor up, and the best pair seen so far is kept in registers.

A controller pulses `start` with both operands present. The engine raises `busy`, and when the search finishes it drops `busy` and pulses `done` for one cycle. At that point the encoded ratio, the encoded divisor, the residual error, a both-edge sampling hint and an out-of-tolerance flag are valid. They stay valid until a later search completes. No data stream crosses this block, so there is no back-pressure. A `start` is accepted only while `busy` is low, and otherwise it is dropped. A search with a baud of zero cannot divide, so it ends at once with `div_zero` set and the previous results untouched.

Top module: `baud_div_search`

## Requirements
- R1: Ratios 4 through 32 are tried in increasing order. For each ratio the floor divisor is clock / (baud × ratio), truncated, and a floor divisor of zero is replaced by 1.
- R2: The low error is clock/(ratio × d) − baud, and the high error is baud − clock/(ratio × (d+1)). Both quotients are truncated and both differences wrap modulo 2^32. The candidate is d+1 with the high error when the high error is strictly smaller; otherwise it is d with the low error.
- R3: The best error starts at the requested baud, with best ratio and divisor zero. A candidate whose error is less than or equal to the best replaces it, so on equal error the larger ratio wins.
- R4: `osr_code` is (selected ratio − 1) in 5 bits, so it lies in 3..31. `sbr_code` is the low 13 bits of the selected divisor. `rate_err` is the selected error.
- R5: `both_edge` is 1 exactly when the selected ratio is between 4 and 7 inclusive, which is `osr_code` 3 to 6.
- R6: `unsupported` is 1 exactly when 100 × `rate_err` > 3 × baud.
- R7: A start with baud equal to zero gives `done` on the next cycle with `div_zero` = 1. `busy` stays low and all result outputs keep their previous values. Any accepted nonzero start clears `div_zero`.
- R8: While `busy` is high, `start` is ignored and the result outputs do not change. `done` is a single-cycle pulse coinciding with `busy` falling.
- R9: After reset `busy`, `done`, `div_zero`, `unsupported`, `both_edge` and all result fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; sampled only while idle |
| ref_hz | input | 32 | Input clock frequency in Hz |
| target_baud | input | 32 | Requested baud rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| osr_code | output | 5 | Selected ratio minus one |
| sbr_code | output | 13 | Selected divisor, low 13 bits |
| rate_err | output | 32 | Residual error of the selected pair |
| both_edge | output | 1 | Selected ratio is 4..7 |
| unsupported | output | 1 | Error above 3 % of the request |
| div_zero | output | 1 | Last start had a zero baud |

## Verification
On every cycle the assertions check the handshake and the encoding rules. These cover the single-cycle `done`, the frozen outputs during a search, the immediate end of a zero-baud search, the range of `osr_code` and its agreement with `both_edge`. Whether the chosen ratio and divisor are actually the closest, including the tie rule, the modulo wrap of the low error and the 13-bit truncation, can only be shown by the bench. It compares complete searches against an independently written model over clock/baud pairs that exercise those cases, and adds hand-computed directed cases.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLOOR,
    ST_LO,
    ST_HI,
    ST_FIN
  } search_state_t;
endpackage

// File: rtl/seq_divider.sv
// Restoring divider: one quotient bit per cycle, fin pulses when quo is valid.
module seq_divider #(
  parameter int NW = 32,
  parameter int DW = 38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem;
  logic [NW-1:0] acc;
  logic [CW-1:0] cnt;
  logic          run;
  logic [DW:0]   trial;

  assign trial = {rem, acc[NW-1]};
  assign quo   = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      acc <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem <= '0;
        acc <= num;
        cnt <= CW'(NW);
        run <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, den}) begin
          rem <= DW'(trial - {1'b0, den});
          acc <= {acc[NW-2:0], 1'b1};
        end else begin
          rem <= DW'(trial);
          acc <= {acc[NW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cand_select.sv
// Chooses between floor divisor and floor+1 and decides whether it beats the best.
module cand_select #(
  parameter int W = 32
) (
  input  logic [W-1:0] baud,
  input  logic [W-1:0] q_lo,
  input  logic [W-1:0] q_hi,
  input  logic [W-1:0] sbr_lo,
  input  logic [W-1:0] best_err,
  output logic [W-1:0] pick_sbr,
  output logic [W-1:0] pick_err,
  output logic         take
);
  logic [W-1:0] err_lo, err_hi;

  always_comb begin
    err_lo = q_lo - baud;
    err_hi = baud - q_hi;
    if (err_lo > err_hi) begin
      pick_sbr = sbr_lo + 1'b1;
      pick_err = err_hi;
    end else begin
      pick_sbr = sbr_lo;
      pick_err = err_lo;
    end
    take = (pick_err <= best_err);
  end
endmodule

// File: rtl/result_encode.sv
// Packs the winning pair into output fields and derives the flags.
module result_encode #(
  parameter int W        = 32,
  parameter int RW       = 6,
  parameter int OSR_BITS = 5,
  parameter int SBR_BITS = 13,
  parameter int EDGE_LO  = 4,
  parameter int EDGE_HI  = 7,
  parameter int TOL_PCT  = 3
) (
  input  logic [RW-1:0]       best_osr,
  input  logic [W-1:0]        best_sbr,
  input  logic [W-1:0]        best_err,
  input  logic [W-1:0]        baud,
  output logic [OSR_BITS-1:0] osr_enc,
  output logic [SBR_BITS-1:0] sbr_enc,
  output logic                edge_hint,
  output logic                out_of_tol
);
  localparam int EW = W + 8;

  logic [EW-1:0] scaled_err, scaled_tol;

  always_comb begin
    osr_enc    = OSR_BITS'(best_osr - 1'b1);
    sbr_enc    = SBR_BITS'(best_sbr);
    edge_hint  = (best_osr >= RW'(EDGE_LO)) && (best_osr <= RW'(EDGE_HI));
    scaled_err = EW'(best_err) * EW'(100);
    scaled_tol = EW'(baud) * EW'(TOL_PCT);
    out_of_tol = scaled_err > scaled_tol;
  end
endmodule

// File: rtl/baud_div_search.sv
module baud_div_search
  import baud_search_pkg::*;
#(
  parameter int W        = 32,
  parameter int OSR_MIN  = 4,
  parameter int OSR_MAX  = 32,
  parameter int OSR_BITS = 5,
  parameter int SBR_BITS = 13,
  parameter int TOL_PCT  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [W-1:0]        ref_hz,
  input  logic [W-1:0]        target_baud,
  output logic                busy,
  output logic                done,
  output logic [OSR_BITS-1:0] osr_code,
  output logic [SBR_BITS-1:0] sbr_code,
  output logic [W-1:0]        rate_err,
  output logic                both_edge,
  output logic                unsupported,
  output logic                div_zero
);
  localparam int RW = $clog2(OSR_MAX + 1);
  localparam int DW = W + RW;

  search_state_t st;
  logic [W-1:0]  ref_l, baud_l, sbr_try, q_lo;
  logic [W-1:0]  best_err, best_sbr;
  logic [RW-1:0] osr_cur, best_osr;
  logic          div_go, div_fin;
  logic [DW-1:0] div_den;
  logic [W-1:0]  div_quo, floor_fix;
  logic [W-1:0]  pick_sbr, pick_err;
  logic          take;
  logic [OSR_BITS-1:0] osr_enc;
  logic [SBR_BITS-1:0] sbr_enc;
  logic          edge_hint, out_of_tol;

  assign floor_fix = (div_quo == '0) ? W'(1) : div_quo;

  seq_divider #(.NW(W), .DW(DW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (ref_l),
    .den  (div_den),
    .fin  (div_fin),
    .quo  (div_quo)
  );

  cand_select #(.W(W)) u_pick (
    .baud    (baud_l),
    .q_lo    (q_lo),
    .q_hi    (div_quo),
    .sbr_lo  (sbr_try),
    .best_err(best_err),
    .pick_sbr(pick_sbr),
    .pick_err(pick_err),
    .take    (take)
  );

  result_encode #(
    .W(W), .RW(RW), .OSR_BITS(OSR_BITS), .SBR_BITS(SBR_BITS),
    .EDGE_LO(4), .EDGE_HI(7), .TOL_PCT(TOL_PCT)
  ) u_enc (
    .best_osr  (best_osr),
    .best_sbr  (best_sbr),
    .best_err  (best_err),
    .baud      (baud_l),
    .osr_enc   (osr_enc),
    .sbr_enc   (sbr_enc),
    .edge_hint (edge_hint),
    .out_of_tol(out_of_tol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      ref_l       <= '0;
      baud_l      <= '0;
      sbr_try     <= '0;
      q_lo        <= '0;
      best_err    <= '0;
      best_sbr    <= '0;
      best_osr    <= '0;
      osr_cur     <= '0;
      div_go      <= 1'b0;
      div_den     <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      osr_code    <= '0;
      sbr_code    <= '0;
      rate_err    <= '0;
      both_edge   <= 1'b0;
      unsupported <= 1'b0;
      div_zero    <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (target_baud == '0) begin
              done     <= 1'b1;
              div_zero <= 1'b1;
            end else begin
              div_zero <= 1'b0;
              ref_l    <= ref_hz;
              baud_l   <= target_baud;
              best_err <= target_baud;
              best_sbr <= '0;
              best_osr <= '0;
              osr_cur  <= RW'(OSR_MIN);
              div_den  <= DW'(target_baud) * DW'(OSR_MIN);
              div_go   <= 1'b1;
              busy     <= 1'b1;
              st       <= ST_FLOOR;
            end
          end
        end
        ST_FLOOR: begin
          if (div_fin) begin
            sbr_try <= floor_fix;
            div_den <= DW'(osr_cur) * DW'(floor_fix);
            div_go  <= 1'b1;
            st      <= ST_LO;
          end
        end
        ST_LO: begin
          if (div_fin) begin
            q_lo    <= div_quo;
            div_den <= DW'(osr_cur) * (DW'(sbr_try) + DW'(1));
            div_go  <= 1'b1;
            st      <= ST_HI;
          end
        end
        ST_HI: begin
          if (div_fin) begin
            if (take) begin
              best_err <= pick_err;
              best_sbr <= pick_sbr;
              best_osr <= osr_cur;
            end
            if (osr_cur == RW'(OSR_MAX)) begin
              st <= ST_FIN;
            end else begin
              osr_cur <= osr_cur + 1'b1;
              div_den <= DW'(baud_l) * (DW'(osr_cur) + DW'(1));
              div_go  <= 1'b1;
              st      <= ST_FLOOR;
            end
          end
        end
        ST_FIN: begin
          osr_code    <= osr_enc;
          sbr_code    <= sbr_enc;
          rate_err    <= best_err;
          both_edge   <= edge_hint;
          unsupported <= out_of_tol;
          busy        <= 1'b0;
          done        <= 1'b1;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/baud_div_search_chk.sv
module baud_div_search_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] target_baud,
  input logic         busy,
  input logic         done,
  input logic [4:0]   osr_code,
  input logic [12:0]  sbr_code,
  input logic [W-1:0] rate_err,
  input logic         both_edge,
  input logic         unsupported,
  input logic         div_zero
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable({osr_code, sbr_code, rate_err, both_edge, unsupported})));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && target_baud != '0) |=> busy);

  p_zero_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && target_baud == '0) |=> (done && div_zero && !busy));

  p_zero_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && target_baud == '0) |=> $stable({osr_code, sbr_code, rate_err}));

  p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (osr_code >= 5'd3));

  p_edge_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (both_edge == (osr_code >= 5'd3 && osr_code <= 5'd6)));
endmodule

bind baud_div_search baud_div_search_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .target_baud(target_baud),
  .busy(busy), .done(done), .osr_code(osr_code), .sbr_code(sbr_code),
  .rate_err(rate_err), .both_edge(both_edge), .unsupported(unsupported),
  .div_zero(div_zero)
);

// File: tb/tb_baud_div_search.sv
`timescale 1ns/1ps
module tb_baud_div_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0, target_baud = '0;
  logic        busy, done, both_edge, unsupported, div_zero;
  logic [4:0]  osr_code;
  logic [12:0] sbr_code;
  logic [31:0] rate_err;

  int applied = 0, miscmp = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  baud_div_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz),
    .target_baud(target_baud), .busy(busy), .done(done),
    .osr_code(osr_code), .sbr_code(sbr_code), .rate_err(rate_err),
    .both_edge(both_edge), .unsupported(unsupported), .div_zero(div_zero)
  );

  // {ref_hz, baud} pairs; expected values come from the model below
  localparam logic [63:0] VEC [8] = '{
    {32'd24000000,  32'd115200},
    {32'd48000000,  32'd9600},
    {32'd8000000,   32'd1000000},
    {32'd1000,      32'd300},
    {32'd100000000, 32'd921600},
    {32'd12000000,  32'd38400},
    {32'd200000000, 32'd300},
    {32'd7000000,   32'd57600}
  };

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    applied++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference search written from R1..R6
  task automatic model(input logic [31:0] c, input logic [31:0] b,
                       output logic [4:0] oc, output logic [12:0] sb,
                       output logic [31:0] e, output logic be, output logic un);
    logic [31:0] be_err = b;
    int bo = 0;
    longint unsigned bs = 0;
    for (int o = 4; o <= 32; o++) begin
      longint unsigned s = longint'(c) / (longint'(b) * o);
      logic [31:0] d, a;
      if (s == 0) s = 1;
      d = 32'(longint'(c) / (o * s)) - b;
      a = b - 32'(longint'(c) / (o * (s + 1)));
      if (d > a) begin
        d = a;
        s = s + 1;
      end
      if (d <= be_err) begin
        be_err = d;
        bo = o;
        bs = s;
      end
    end
    oc = 5'(bo - 1);
    sb = 13'(bs);
    e  = be_err;
    be = (bo > 3) && (bo < 8);
    un = (longint'(be_err) * 100) > (longint'(b) * 3);
  endtask

  task automatic pulse_start(input logic [31:0] c, input logic [31:0] b);
    @(negedge clk);
    ref_hz = c;
    target_baud = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin
        ok = 1;
        break;
      end
      @(negedge clk);
    end
    if (!ok) check("R8", "done timeout", 0, 1);
  endtask

  task automatic check_result(input string req, input logic [31:0] c, input logic [31:0] b);
    logic [4:0] oc;
    logic [12:0] sb;
    logic [31:0] e;
    logic be, un;
    model(c, b, oc, sb, e, be, un);
    check({req, " R1 R2 R3 R4"}, "osr_code", osr_code, oc);
    check({req, " R1 R2 R3 R4"}, "sbr_code", sbr_code, sb);
    check({req, " R2 R3"}, "rate_err", rate_err, e);
    check({req, " R5"}, "both_edge", both_edge, be);
    check({req, " R6"}, "unsupported", unsupported, un);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      miscmp++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [4:0] h_oc;
    logic [12:0] h_sb;
    logic [31:0] h_e;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "busy", busy, 0);
    check("R9", "done", done, 0);
    check("R9", "fields", {osr_code, sbr_code, rate_err}, 0);
    check("R9", "flags", {both_edge, unsupported, div_zero}, 0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < 8; i++) begin
      pulse_start(VEC[i][63:32], VEC[i][31:0]);
      check("R8", "busy after start", busy, 1);
      wait_done(ok);
      if (ok) check_result($sformatf("vec%0d", i), VEC[i][63:32], VEC[i][31:0]);
      @(negedge clk);
      check("R8", "done single pulse", done, 0);
    end

    // R6 directed: 1000 Hz / 300 baud -> ratio 4, divisor 2, error 175
    pulse_start(32'd1000, 32'd300);
    wait_done(ok);
    check("R6", "osr_code", osr_code, 3);
    check("R6", "sbr_code", sbr_code, 2);
    check("R6", "rate_err", rate_err, 175);
    check("R6", "unsupported", unsupported, 1);

    // R8 directed: start during busy ignored; 5 MHz / 1 MHz -> ratio 5, divisor 1, exact
    pulse_start(32'd5000000, 32'd1000000);
    repeat (100) @(negedge clk);
    h_oc = osr_code; h_sb = sbr_code; h_e = rate_err;
    start = 1'b1; ref_hz = 32'd48000000; target_baud = 32'd9600;
    @(negedge clk);
    start = 1'b0; target_baud = 32'd0;
    @(negedge clk);
    check("R8", "still busy", busy, 1);
    check("R8", "outputs frozen", {osr_code, sbr_code, rate_err}, {h_oc, h_sb, h_e});
    wait_done(ok);
    check("R8 R5", "osr_code", osr_code, 4);
    check("R8", "sbr_code", sbr_code, 1);
    check("R8", "rate_err", rate_err, 0);
    check("R5", "both_edge", both_edge, 1);
    check("R7", "div_zero clear", div_zero, 0);

    // R7: zero baud ends at once, results kept
    @(negedge clk);
    pulse_start(32'd24000000, 32'd0);
    check("R7", "done", done, 1);
    check("R7", "div_zero", div_zero, 1);
    check("R7", "busy", busy, 0);
    check("R7", "fields kept", {osr_code, sbr_code, rate_err}, {5'd4, 13'd1, 32'd0});
    @(negedge clk);
    check("R7", "done pulse ends", done, 0);

    // R7: next nonzero search clears flag
    pulse_start(32'd24000000, 32'd115200);
    wait_done(ok);
    check("R7", "div_zero cleared", div_zero, 0);
    check_result("R7 rerun", 32'd24000000, 32'd115200);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end
endmodule